// File: doc/BRIEF.md
# MII Loopback and Monitor Mirror Switch

This block sits between the media access controllers of a multi-port Ethernet controller and their MII pins. Each port has its own loopback control. With loopback active, the nibble stream that the controller sends (data, enable, error) is returned to the same controller as its receive stream. The receive clock is taken from the port's transmit clock. Collision and carrier sense from the PHY are held low. Loopback needs the port's full-duplex setting as well. A loopback request without full duplex leaves the path in normal operation and raises a per-port configuration error flag.

A monitoring feature copies one stream onto the transmit pins of a fixed monitor port. It can take either the transmit stream or the controller-side receive stream of any selected port. While the copy is active, the monitor port's own transmit stream is kept off its pins. All ports share one clock. Configuration inputs are registered once, and the mirrored stream passes through one register stage.

Top module: `mii_switch`

## Requirements
- R1: When a port's effective loopback is on, its controller-side receive data, data-valid and error equal that same port's transmit data, enable and error in the same cycle.
- R2: A port's controller receive clock equals its PHY transmit clock while effective loopback is on, and its PHY receive clock otherwise.
- R3: During effective loopback, the port's controller-side collision and carrier-sense outputs are 0 whatever the PHY drives. Otherwise they follow the PHY.
- R4: Effective loopback requires both the loopback bit and the full-duplex bit. A loopback bit without full duplex leaves the port in normal receive operation and sets that port's bit of cfg_err. cfg_err is 0 for every other combination.
- R5: Each port's loopback is independent: a port without loopback passes PHY receive signals to its controller unchanged while another port loops.
- R6: Loopback and error-flag settings take effect on the first rising clock edge after they are presented. Outputs keep the previous setting until that edge.
- R7: During effective loopback, the port's PHY transmit pins (data, enable, error) are driven to 0, unless the port is the monitor port with mirroring active.
- R8: With the mirror enabled, the monitor port's PHY transmit pins carry the selected stream one clock later. Direction 1 selects the selected port's controller transmit stream. Direction 0 selects its controller-side receive stream, which is the looped stream when that port loops. Mirroring starts on the second clock edge after enabling.
- R9: While mirroring is active, the monitor port's own controller transmit stream does not reach its pins. With the mirror disabled, the monitor pins carry the monitor port's own transmit stream.
- R10: While rst is high, loopback and mirroring are off and cfg_err is 0, whatever the configuration inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all ports |
| rst | input | 1 | Synchronous active-high reset |
| cfg_loop_en | input | N_PORTS | Per-port loopback request |
| cfg_full_dup | input | N_PORTS | Per-port full-duplex setting |
| cfg_mir_en | input | 1 | Mirror enable |
| cfg_mir_port | input | PW | Index of the port to mirror |
| cfg_mir_dir | input | 1 | Mirror direction: 1 transmit, 0 receive |
| cfg_err | output | N_PORTS | Loopback requested without full duplex |
| mac_txd | input | 4*N_PORTS | Controller transmit nibbles |
| mac_tx_en | input | N_PORTS | Controller transmit enable |
| mac_tx_er | input | N_PORTS | Controller transmit error |
| mac_rxd | output | 4*N_PORTS | Controller receive nibbles |
| mac_rx_dv | output | N_PORTS | Controller receive data valid |
| mac_rx_er | output | N_PORTS | Controller receive error |
| mac_col | output | N_PORTS | Collision seen by controller |
| mac_crs | output | N_PORTS | Carrier sense seen by controller |
| mac_rx_clk | output | N_PORTS | Receive clock seen by controller |
| phy_tx_clk | input | N_PORTS | Transmit clock from PHY |
| phy_rx_clk | input | N_PORTS | Receive clock from PHY |
| phy_rxd | input | 4*N_PORTS | PHY receive nibbles |
| phy_rx_dv | input | N_PORTS | PHY receive data valid |
| phy_rx_er | input | N_PORTS | PHY receive error |
| phy_col | input | N_PORTS | PHY collision |
| phy_crs | input | N_PORTS | PHY carrier sense |
| phy_txd | output | 4*N_PORTS | Transmit nibbles to PHY |
| phy_tx_en | output | N_PORTS | Transmit enable to PHY |
| phy_tx_er | output | N_PORTS | Transmit error to PHY |

## Verification
The properties assume that every port runs on the single shared clock. The clock pins of each port are treated as plain levels sampled on that clock, and no true second clock domain is involved. They also assume that configuration and data inputs change only between rising edges. The bench changes every input on the falling edge and keeps the PHY clock pins at steady levels, so the receive-clock selection can be observed as a level. The mirror checks keep the selected source constant across the capturing edge, so the one-cycle delay can be compared directly against the value that was driven.

// File: rtl/mii_sw_pkg.sv
package mii_sw_pkg;

    localparam int NIB_W = 4;

    // one direction of an MII stream: nibble, qualifier, error
    typedef struct packed {
        logic [NIB_W-1:0] d;
        logic             v;
        logic             e;
    } mii_lane_t;

    typedef enum logic {
        MIR_RX = 1'b0,
        MIR_TX = 1'b1
    } mir_dir_e;

    function automatic mii_lane_t lane_idle();
        mii_lane_t l;
        l = '0;
        return l;
    endfunction

    function automatic mii_lane_t lane_pick(input logic sel, input mii_lane_t a, input mii_lane_t b);
        return sel ? a : b;
    endfunction

endpackage

// File: rtl/mii_mode_regs.sv
module mii_mode_regs
    import mii_sw_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int PW      = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_PORTS-1:0] loop_req,
    input  logic [N_PORTS-1:0] full_dup,
    input  logic               mir_en_in,
    input  logic [PW-1:0]      mir_port_in,
    input  logic               mir_dir_in,
    output logic [N_PORTS-1:0] loop_act,
    output logic [N_PORTS-1:0] loop_err,
    output logic               mir_en,
    output logic [PW-1:0]      mir_port,
    output mir_dir_e           mir_dir
);

    always_ff @(posedge clk) begin
        if (rst) begin
            loop_act <= '0;
            loop_err <= '0;
            mir_en   <= 1'b0;
            mir_port <= '0;
            mir_dir  <= MIR_RX;
        end else begin
            loop_act <= loop_req & full_dup;
            loop_err <= loop_req & ~full_dup;
            mir_en   <= mir_en_in;
            mir_port <= mir_port_in;
            mir_dir  <= mir_dir_e'(mir_dir_in);
        end
    end

endmodule

// File: rtl/mii_port_path.sv
module mii_port_path
    import mii_sw_pkg::*;
(
    input  logic      loop_on,
    input  mii_lane_t mac_tx,
    input  mii_lane_t phy_rx,
    input  logic      phy_col_in,
    input  logic      phy_crs_in,
    input  logic      tx_clk_in,
    input  logic      rx_clk_in,
    output mii_lane_t mac_rx,
    output logic      mac_col_out,
    output logic      mac_crs_out,
    output logic      mac_rx_clk_out,
    output mii_lane_t pin_tx
);

    always_comb begin
        mac_rx         = lane_pick(loop_on, mac_tx, phy_rx);
        pin_tx         = lane_pick(loop_on, lane_idle(), mac_tx);
        mac_col_out    = phy_col_in & ~loop_on;
        mac_crs_out    = phy_crs_in & ~loop_on;
        mac_rx_clk_out = loop_on ? tx_clk_in : rx_clk_in;
    end

endmodule

// File: rtl/mii_mirror.sv
module mii_mirror
    import mii_sw_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int PW      = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mir_en,
    input  logic [PW-1:0]           mir_port,
    input  mir_dir_e                mir_dir,
    input  mii_lane_t [N_PORTS-1:0] tx_lanes,
    input  mii_lane_t [N_PORTS-1:0] rx_lanes,
    input  mii_lane_t               own_tx,
    output mii_lane_t               mon_tx
);

    logic      sel_ok;
    mii_lane_t src;
    mii_lane_t cap_q;
    logic      act_q;

    always_comb begin
        sel_ok = ({{(32-PW){1'b0}}, mir_port} < N_PORTS);
        src    = lane_idle();
        if (sel_ok) begin
            src = (mir_dir == MIR_TX) ? tx_lanes[mir_port] : rx_lanes[mir_port];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            act_q <= 1'b0;
        end else begin
            cap_q <= src;
            act_q <= mir_en & sel_ok;
        end
    end

    assign mon_tx = lane_pick(act_q, cap_q, own_tx);

endmodule

// File: rtl/mii_switch.sv
module mii_switch
    import mii_sw_pkg::*;
#(
    parameter  int N_PORTS  = 4,
    parameter  int MON_PORT = N_PORTS - 1,
    localparam int PW       = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_PORTS-1:0]       cfg_loop_en,
    input  logic [N_PORTS-1:0]       cfg_full_dup,
    input  logic                     cfg_mir_en,
    input  logic [PW-1:0]            cfg_mir_port,
    input  logic                     cfg_mir_dir,
    output logic [N_PORTS-1:0]       cfg_err,
    input  logic [NIB_W*N_PORTS-1:0] mac_txd,
    input  logic [N_PORTS-1:0]       mac_tx_en,
    input  logic [N_PORTS-1:0]       mac_tx_er,
    output logic [NIB_W*N_PORTS-1:0] mac_rxd,
    output logic [N_PORTS-1:0]       mac_rx_dv,
    output logic [N_PORTS-1:0]       mac_rx_er,
    output logic [N_PORTS-1:0]       mac_col,
    output logic [N_PORTS-1:0]       mac_crs,
    output logic [N_PORTS-1:0]       mac_rx_clk,
    input  logic [N_PORTS-1:0]       phy_tx_clk,
    input  logic [N_PORTS-1:0]       phy_rx_clk,
    input  logic [NIB_W*N_PORTS-1:0] phy_rxd,
    input  logic [N_PORTS-1:0]       phy_rx_dv,
    input  logic [N_PORTS-1:0]       phy_rx_er,
    input  logic [N_PORTS-1:0]       phy_col,
    input  logic [N_PORTS-1:0]       phy_crs,
    output logic [NIB_W*N_PORTS-1:0] phy_txd,
    output logic [N_PORTS-1:0]       phy_tx_en,
    output logic [N_PORTS-1:0]       phy_tx_er
);

    logic [N_PORTS-1:0]      loop_act;
    logic                    mir_en;
    logic [PW-1:0]           mir_port;
    mir_dir_e                mir_dir;
    mii_lane_t [N_PORTS-1:0] tx_l;
    mii_lane_t [N_PORTS-1:0] prx_l;
    mii_lane_t [N_PORTS-1:0] mrx_l;
    mii_lane_t [N_PORTS-1:0] pin_l;
    mii_lane_t               mon_l;

    mii_mode_regs #(.N_PORTS(N_PORTS), .PW(PW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .loop_req   (cfg_loop_en),
        .full_dup   (cfg_full_dup),
        .mir_en_in  (cfg_mir_en),
        .mir_port_in(cfg_mir_port),
        .mir_dir_in (cfg_mir_dir),
        .loop_act   (loop_act),
        .loop_err   (cfg_err),
        .mir_en     (mir_en),
        .mir_port   (mir_port),
        .mir_dir    (mir_dir)
    );

    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        assign tx_l[i]  = '{d: mac_txd[i*NIB_W +: NIB_W], v: mac_tx_en[i], e: mac_tx_er[i]};
        assign prx_l[i] = '{d: phy_rxd[i*NIB_W +: NIB_W], v: phy_rx_dv[i], e: phy_rx_er[i]};

        mii_port_path u_path (
            .loop_on       (loop_act[i]),
            .mac_tx        (tx_l[i]),
            .phy_rx        (prx_l[i]),
            .phy_col_in    (phy_col[i]),
            .phy_crs_in    (phy_crs[i]),
            .tx_clk_in     (phy_tx_clk[i]),
            .rx_clk_in     (phy_rx_clk[i]),
            .mac_rx        (mrx_l[i]),
            .mac_col_out   (mac_col[i]),
            .mac_crs_out   (mac_crs[i]),
            .mac_rx_clk_out(mac_rx_clk[i]),
            .pin_tx        (pin_l[i])
        );

        assign mac_rxd[i*NIB_W +: NIB_W] = mrx_l[i].d;
        assign mac_rx_dv[i]              = mrx_l[i].v;
        assign mac_rx_er[i]              = mrx_l[i].e;

        if (i == MON_PORT) begin : g_mon
            assign phy_txd[i*NIB_W +: NIB_W] = mon_l.d;
            assign phy_tx_en[i]              = mon_l.v;
            assign phy_tx_er[i]              = mon_l.e;
        end else begin : g_norm
            assign phy_txd[i*NIB_W +: NIB_W] = pin_l[i].d;
            assign phy_tx_en[i]              = pin_l[i].v;
            assign phy_tx_er[i]              = pin_l[i].e;
        end
    end

    mii_mirror #(.N_PORTS(N_PORTS), .PW(PW)) u_mirror (
        .clk     (clk),
        .rst     (rst),
        .mir_en  (mir_en),
        .mir_port(mir_port),
        .mir_dir (mir_dir),
        .tx_lanes(tx_l),
        .rx_lanes(mrx_l),
        .own_tx  (pin_l[MON_PORT]),
        .mon_tx  (mon_l)
    );

endmodule

// File: rtl/mii_switch_chk.sv
module mii_switch_chk
    import mii_sw_pkg::*;
#(
    parameter int N_PORTS  = 4,
    parameter int MON_PORT = N_PORTS - 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_PORTS-1:0]       cfg_loop_en,
    input logic [N_PORTS-1:0]       cfg_full_dup,
    input logic [N_PORTS-1:0]       cfg_err,
    input logic [NIB_W*N_PORTS-1:0] mac_txd,
    input logic [N_PORTS-1:0]       mac_tx_en,
    input logic [N_PORTS-1:0]       mac_tx_er,
    input logic [NIB_W*N_PORTS-1:0] mac_rxd,
    input logic [N_PORTS-1:0]       mac_rx_dv,
    input logic [N_PORTS-1:0]       mac_rx_er,
    input logic [N_PORTS-1:0]       mac_col,
    input logic [N_PORTS-1:0]       mac_crs,
    input logic [N_PORTS-1:0]       mac_rx_clk,
    input logic [N_PORTS-1:0]       phy_tx_clk,
    input logic [N_PORTS-1:0]       phy_rx_clk,
    input logic [NIB_W*N_PORTS-1:0] phy_txd,
    input logic [N_PORTS-1:0]       phy_tx_en,
    input logic [N_PORTS-1:0]       phy_tx_er
);

    logic seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
        // R1
        p_loop_data_r1: assert property (@(posedge clk) disable iff (rst)
            seen && $past(cfg_loop_en[i] && cfg_full_dup[i]) |->
                mac_rxd[i*NIB_W +: NIB_W] == mac_txd[i*NIB_W +: NIB_W] &&
                mac_rx_dv[i] == mac_tx_en[i] && mac_rx_er[i] == mac_tx_er[i]);

        // R2
        p_rx_clk_src_r2: assert property (@(posedge clk) disable iff (rst)
            seen |-> mac_rx_clk[i] ==
                ($past(cfg_loop_en[i] && cfg_full_dup[i]) ? phy_tx_clk[i] : phy_rx_clk[i]));

        // R3
        p_col_crs_mask_r3: assert property (@(posedge clk) disable iff (rst)
            seen && $past(cfg_loop_en[i] && cfg_full_dup[i]) |-> !mac_col[i] && !mac_crs[i]);

        // R4
        p_cfg_err_r4: assert property (@(posedge clk) disable iff (rst)
            seen |-> cfg_err[i] == $past(cfg_loop_en[i] && !cfg_full_dup[i]));

        if (i != MON_PORT) begin : g_pin
            // R7
            p_pins_idle_r7: assert property (@(posedge clk) disable iff (rst)
                seen && $past(cfg_loop_en[i] && cfg_full_dup[i]) |->
                    phy_txd[i*NIB_W +: NIB_W] == '0 && !phy_tx_en[i] && !phy_tx_er[i]);
        end
    end

endmodule

bind mii_switch mii_switch_chk #(.N_PORTS(N_PORTS), .MON_PORT(MON_PORT)) u_chk (.*);

// File: tb/sim_mii_switch.sv
module sim_mii_switch;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int MON = 3;

    // vector: txd[19:16] en[15] er[14] prxd[13:10] pdv[9] per[8] col[7] crs[6] exp_rxd[5:2] exp_dv[1] exp_er[0]
    localparam int NV = 6;
    localparam logic [19:0] VEC [NV] = '{
        {4'h5, 1'b1, 1'b0, 4'hA, 1'b1, 1'b1, 1'b1, 1'b1, 4'h5, 1'b1, 1'b0},
        {4'hD, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hD, 1'b1, 1'b0},
        {4'h0, 1'b0, 1'b1, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1},
        {4'hF, 1'b1, 1'b1, 4'h3, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 1'b1},
        {4'h8, 1'b0, 1'b0, 4'h7, 1'b1, 1'b1, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0},
        {4'h1, 1'b1, 1'b0, 4'hE, 1'b1, 1'b0, 1'b1, 1'b1, 4'h1, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]   cfg_loop_en = '0, cfg_full_dup = '0;
    logic           cfg_mir_en = 1'b0, cfg_mir_dir = 1'b0;
    logic [1:0]     cfg_mir_port = '0;
    logic [N-1:0]   cfg_err;
    logic [4*N-1:0] mac_txd = '0, mac_rxd, phy_rxd = '0, phy_txd;
    logic [N-1:0]   mac_tx_en = '0, mac_tx_er = '0, mac_rx_dv, mac_rx_er, mac_col, mac_crs, mac_rx_clk;
    logic [N-1:0]   phy_tx_clk = '1, phy_rx_clk = '0;
    logic [N-1:0]   phy_rx_dv = '0, phy_rx_er = '0, phy_col = '0, phy_crs = '0;
    logic [N-1:0]   phy_tx_en, phy_tx_er;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mii_switch #(.N_PORTS(N), .MON_PORT(MON)) u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [N-1:0] lp, input logic [N-1:0] fd,
                             input logic men, input logic [1:0] mport, input logic mdir);
        @(negedge clk);
        cfg_loop_en = lp; cfg_full_dup = fd;
        cfg_mir_en = men; cfg_mir_port = mport; cfg_mir_dir = mdir;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R10: config asks for loopback and mirror while in reset
        @(negedge clk);
        cfg_loop_en = '1; cfg_full_dup = '1; cfg_mir_en = 1'b1; cfg_mir_dir = 1'b1;
        phy_rxd[3:0] = 4'h6; phy_rx_dv[0] = 1'b1; phy_col[0] = 1'b1;
        mac_txd[15:12] = 4'h9; mac_tx_en[3] = 1'b1; mac_txd[3:0] = 4'h2;
        repeat (3) @(negedge clk);
        #1;
        chk(cfg_err == '0, "R10", 32'(cfg_err), 0);
        chk(mac_rxd[3:0] == 4'h6 && mac_col[0], "R10", 32'(mac_rxd[3:0]), 32'h6);
        chk(phy_txd[15:12] == 4'h9 && phy_tx_en[3], "R10", 32'(phy_txd[15:12]), 32'h9);
        cfg_loop_en = '0; cfg_full_dup = '0; cfg_mir_en = 1'b0; cfg_mir_dir = 1'b0;
        rst = 1'b0;

        // R1 R2 R3 R5 R7: port 0 loops, port 1 stays normal
        apply_cfg(4'b0001, 4'b0011, 1'b0, 2'd0, 1'b0);
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            mac_txd[3:0] = VEC[k][19:16]; mac_tx_en[0] = VEC[k][15]; mac_tx_er[0] = VEC[k][14];
            phy_rxd[3:0] = VEC[k][13:10]; phy_rx_dv[0] = VEC[k][9]; phy_rx_er[0] = VEC[k][8];
            phy_col[0] = VEC[k][7]; phy_crs[0] = VEC[k][6];
            phy_rxd[7:4] = VEC[k][13:10]; phy_rx_dv[1] = VEC[k][9]; phy_rx_er[1] = VEC[k][8];
            phy_col[1] = VEC[k][7]; phy_crs[1] = VEC[k][6];
            #1;
            chk({mac_rxd[3:0], mac_rx_dv[0], mac_rx_er[0]} == VEC[k][5:0], "R1",
                32'({mac_rxd[3:0], mac_rx_dv[0], mac_rx_er[0]}), 32'(VEC[k][5:0]));
            chk(!mac_col[0] && !mac_crs[0], "R3", 32'({mac_col[0], mac_crs[0]}), 0);
            chk(mac_rx_clk == 4'b0001, "R2", 32'(mac_rx_clk), 32'h1);
            chk(phy_txd[3:0] == 4'h0 && !phy_tx_en[0] && !phy_tx_er[0], "R7",
                32'({phy_txd[3:0], phy_tx_en[0], phy_tx_er[0]}), 0);
            chk({mac_rxd[7:4], mac_rx_dv[1], mac_rx_er[1], mac_col[1], mac_crs[1]} == VEC[k][13:6], "R5",
                32'({mac_rxd[7:4], mac_rx_dv[1], mac_rx_er[1], mac_col[1], mac_crs[1]}), 32'(VEC[k][13:6]));
        end

        // R4: port 2 loop request without full duplex
        apply_cfg(4'b0101, 4'b0011, 1'b0, 2'd0, 1'b0);
        @(negedge clk);
        mac_txd[11:8] = 4'h4; mac_tx_en[2] = 1'b1;
        phy_rxd[11:8] = 4'hB; phy_rx_dv[2] = 1'b1; phy_crs[2] = 1'b1;
        #1;
        chk(cfg_err == 4'b0100, "R4", 32'(cfg_err), 32'h4);
        chk(mac_rxd[11:8] == 4'hB && mac_crs[2] && !mac_rx_clk[2], "R4", 32'(mac_rxd[11:8]), 32'hB);
        chk(phy_txd[11:8] == 4'h4 && phy_tx_en[2], "R4", 32'(phy_txd[11:8]), 32'h4);
        apply_cfg(4'b0101, 4'b0111, 1'b0, 2'd0, 1'b0);
        #1;
        chk(cfg_err == 4'b0000, "R4", 32'(cfg_err), 0);
        chk(mac_rxd[11:8] == 4'h4 && !mac_crs[2], "R4", 32'(mac_rxd[11:8]), 32'h4);

        // R6: port 1 setting applies only after the next rising edge
        @(negedge clk);
        cfg_loop_en[1] = 1'b1;
        cfg_full_dup[3] = 1'b0;
        mac_txd[7:4] = 4'h2; mac_tx_en[1] = 1'b1; phy_rxd[7:4] = 4'hC;
        #1;
        chk(mac_rxd[7:4] == 4'hC, "R6", 32'(mac_rxd[7:4]), 32'hC);
        @(negedge clk);
        #1;
        chk(mac_rxd[7:4] == 4'h2, "R6", 32'(mac_rxd[7:4]), 32'h2);
        chk(mac_rx_clk == 4'b0111, "R6", 32'(mac_rx_clk), 32'h7);

        // R8 R9: mirror transmit stream of port 1 (normal again) onto port 3
        apply_cfg(4'b0001, 4'b0011, 1'b1, 2'd1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            mac_txd[7:4] = 4'(k + 3); mac_tx_en[1] = 1'b1; mac_tx_er[1] = k[0];
            mac_txd[15:12] = 4'h9; mac_tx_en[3] = 1'b1; mac_tx_er[3] = 1'b0;
            @(negedge clk);
            #1;
            chk(phy_txd[15:12] == 4'(k + 3) && phy_tx_en[3] && phy_tx_er[3] == k[0], "R8",
                32'(phy_txd[15:12]), 32'(k + 3));
            chk(phy_txd[15:12] != 4'h9 || phy_tx_er[3] != 1'b0, "R9", 32'(phy_txd[15:12]), 32'(k + 3));
        end

        // R8: receive direction of looped port 0 shows its own transmit stream
        apply_cfg(4'b0001, 4'b0011, 1'b1, 2'd0, 1'b0);
        @(negedge clk);
        mac_txd[3:0] = 4'hC; mac_tx_en[0] = 1'b1; mac_tx_er[0] = 1'b0;
        phy_rxd[3:0] = 4'h1;
        @(negedge clk);
        #1;
        chk(phy_txd[15:12] == 4'hC && phy_tx_en[3] && !phy_tx_er[3], "R8", 32'(phy_txd[15:12]), 32'hC);

        // R8: receive direction of normal port 2 shows PHY data
        apply_cfg(4'b0001, 4'b0011, 1'b1, 2'd2, 1'b0);
        @(negedge clk);
        phy_rxd[11:8] = 4'h6; phy_rx_dv[2] = 1'b1; phy_rx_er[2] = 1'b1;
        @(negedge clk);
        #1;
        chk(phy_txd[15:12] == 4'h6 && phy_tx_en[3] && phy_tx_er[3], "R8", 32'(phy_txd[15:12]), 32'h6);

        // R9: mirror off returns the monitor pins to the port's own stream
        apply_cfg(4'b0001, 4'b0011, 1'b0, 2'd2, 1'b0);
        @(negedge clk);
        mac_txd[15:12] = 4'h4; mac_tx_en[3] = 1'b1; mac_tx_er[3] = 1'b0;
        #1;
        chk(phy_txd[15:12] == 4'h4 && phy_tx_en[3] && !phy_tx_er[3], "R9", 32'(phy_txd[15:12]), 32'h4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule